// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges three reset causes into a single active-high system reset: a supply-monitor comparator output, an active-low external reset pin, and a missing-clock detector. The detector watches the system clock from a free-running reference clock. All logic, including a small two-register write/read interface, runs in the reference-clock domain. The block's own power-on reset (`por_n`) clears every register.

The control register enables the supply monitor and shows the live, synchronized comparator level. The source register does three jobs. Writes select the supply monitor as a reset source and switch the missing-clock detector on or off. Reads return sticky flags that record which source began the most recent reset.

A model stabilization counter stands in for the analog turn-on time of the monitor. Arming the monitor before that counter finishes produces a single-cycle glitch reset, so the hazard can be exercised. After every reset episode, the output is held for a parameterized stretch time. The one exception is an episode begun by the supply monitor, which releases at once.

Top module: `reset_hub`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1 and both registers read 0 except the status bit. After `por_n` rises with no cause active, `sys_rst` stays 1 for exactly STRETCH_CYCLES reference cycles.
- R2: The control register at address 0xFF has three fields. Bit 7 is the read/write monitor enable. Bit 6 is read-only and returns the comparator level after a SYNC_STAGES-flop synchronizer (1 = supply above threshold). Bits 5..0 read 0 and ignore writes.
- R3: The source register at address 0xFE reads as follows: bit 0 = pin flag, bit 1 = supply flag, bit 2 = missing-clock flag, bits 7..3 = 0. Writing bit 1 selects the monitor as a source. Writing bit 2 enables (1) or disables (0) the missing-clock detector. Writes never change the flags. Any other address reads 0.
- R4: A low level on `ext_rst_n`, once synchronized, asserts `sys_rst` on the following reference edge and holds it while the pin stays low.
- R5: The supply monitor causes a reset only while it is enabled, selected and ready, and the synchronized comparator reads 0. If either the enable or the select is clear, a low comparator has no effect.
- R6: Readiness comes STAB_CYCLES+1 reference cycles after the enable is set and is lost when the enable is cleared. Before readiness, a low comparator causes no reset.
- R7: When enable and select first become true together while the monitor is not ready, the supply cause is active for exactly one cycle. This gives a one-cycle `sys_rst` pulse that counts as a supply-monitor episode.
- R8: With the detector enabled, a reset is raised once more than MCD_TIMEOUT reference cycles pass without a synchronized edge of `sys_clk`. That cause lasts until the next edge. With the detector disabled, a stopped clock has no effect.
- R9: When the set of active causes goes from empty to non-empty, the flags are replaced by a one-hot code of the winning source, with priority pin over supply over missing-clock. The flags then stay unchanged until the next such event.
- R10: After the last cycle with an active cause, `sys_rst` remains 1 for STRETCH_CYCLES more cycles. When the episode's flag is the supply flag, it drops on the next edge instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all logic runs on it |
| por_n | input | 1 | Asynchronous active-low power-on reset of the block |
| sys_clk | input | 1 | Monitored system clock |
| ext_rst_n | input | 1 | External reset pin, active low |
| sup_above | input | 1 | Supply comparator output, 1 = above threshold |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sys_rst | output | 1 | Active-high system reset |

## Verification
The bench builds the block with MCD_TIMEOUT=20, STAB_CYCLES=16, STRETCH_CYCLES=5 and SYNC_STAGES=2. With these values a clock stall, a full stabilization wait and a stretch tail each fit within a few tens of cycles. That makes it practical to test the unready-select glitch before readiness, a level reset after readiness, detector timeout and recovery, and simultaneous pin and supply causes, all in one short run. A system clock toggling every three reference cycles stays well inside the timeout, so any reset seen while it runs is a false alarm.

// File: rtl/reset_hub_pkg.sv
`timescale 1ns/1ps
package reset_hub_pkg;

   localparam int unsigned REG_W    = 8;
   localparam int unsigned NUM_SRC  = 3;

   localparam int unsigned CTRL_EN_BIT   = 7;
   localparam int unsigned CTRL_STAT_BIT = 6;
   localparam int unsigned SRC_SEL_BIT   = 1;
   localparam int unsigned SRC_MCD_BIT   = 2;

   // Packed so that pin lands on bit 0, supply on bit 1, clock loss on bit 2.
   typedef struct packed {
      logic mcd;
      logic sup;
      logic pin;
   } src_vec_t;

   function automatic src_vec_t pick_winner(src_vec_t c);
      src_vec_t w;
      w = '0;
      if (c.pin)      w.pin = 1'b1;
      else if (c.sup) w.sup = 1'b1;
      else if (c.mcd) w.mcd = 1'b1;
      return w;
   endfunction

endpackage

// File: rtl/rh_sync.sv
`timescale 1ns/1ps
module rh_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rh_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rh_mcd.sv
`timescale 1ns/1ps
module rh_mcd #(
   parameter int unsigned TIMEOUT = 1000,
   parameter int unsigned SYNC    = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic mon_clk,
   input  logic enable,
   output logic missing
);

   localparam int unsigned CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

   generate
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("rh_mcd: TIMEOUT must be at least 2");
      end
   endgenerate

   logic          clk_s;
   logic          clk_d;
   logic          edge_seen;
   logic [CW-1:0] cnt;

   rh_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_clk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mon_clk),
      .q     (clk_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_d <= 1'b0;
      else        clk_d <= clk_s;
   end

   assign edge_seen = clk_s ^ clk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         missing <= 1'b0;
      end else if (!enable || edge_seen) begin
         cnt     <= '0;
         missing <= 1'b0;
      end else if (cnt == LIMIT) begin
         missing <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_EDGE_CLEARS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && edge_seen) |=> !missing); // R8
   AST_OFF_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !missing); // R8

endmodule

// File: rtl/rh_supmon.sv
`timescale 1ns/1ps
module rh_supmon #(
   parameter int unsigned STAB = 500,
   parameter int unsigned SYNC = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sup_above,
   input  logic en,
   input  logic sel,
   output logic status,
   output logic ready,
   output logic cause
);

   localparam int unsigned SW = $clog2(STAB + 1);
   localparam logic [SW-1:0] STAB_LIM = SW'(STAB);

   generate
      if (STAB < 1) begin : g_bad_stab
         $error("rh_supmon: STAB must be at least 1");
      end
   endgenerate

   logic [SW-1:0] stab_cnt;
   logic          armed;
   logic          armed_d;
   logic          hazard;

   rh_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_cmp_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sup_above),
      .q     (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stab_cnt <= '0;
         ready    <= 1'b0;
      end else if (!en) begin
         stab_cnt <= '0;
         ready    <= 1'b0;
      end else if (stab_cnt == STAB_LIM) begin
         ready <= 1'b1;
      end else begin
         stab_cnt <= stab_cnt + 1'b1;
      end
   end

   assign armed = en & sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_d <= 1'b0;
      else        armed_d <= armed;
   end

   assign hazard = armed & ~armed_d & ~ready;
   assign cause  = hazard | (armed & ready & ~status);

   AST_HAZARD_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hazard |=> !hazard); // R7
   AST_EN_OFF_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !ready); // R6

endmodule

// File: rtl/rh_stretch.sv
`timescale 1ns/1ps
module rh_stretch #(
   parameter int unsigned HOLD = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic any,
   input  logic skip,
   output logic rst_out
);

   generate
      if (HOLD == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_out <= 1'b1;
            else        rst_out <= any;
         end
      end else begin : g_counted
         localparam int unsigned HW = $clog2(HOLD + 1);
         localparam logic [HW-1:0] HOLD_V = HW'(HOLD);
         logic [HW-1:0] hold;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rst_out <= 1'b1;
               hold    <= HOLD_V;
            end else if (any) begin
               rst_out <= 1'b1;
               hold    <= skip ? '0 : HOLD_V;
            end else if (hold != '0) begin
               rst_out <= 1'b1;
               hold    <= hold - 1'b1;
            end else begin
               rst_out <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/reset_hub.sv
`timescale 1ns/1ps
module reset_hub
   import reset_hub_pkg::*;
#(
   parameter int unsigned MCD_TIMEOUT    = 1000,
   parameter int unsigned STAB_CYCLES    = 500,
   parameter int unsigned STRETCH_CYCLES = 64,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter logic [7:0]  CTRL_ADDR      = 8'hFF,
   parameter logic [7:0]  SRC_ADDR       = 8'hFE
)(
   input  logic             ref_clk,
   input  logic             por_n,
   input  logic             sys_clk,
   input  logic             ext_rst_n,
   input  logic             sup_above,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sys_rst
);

   generate
      if (CTRL_ADDR == SRC_ADDR) begin : g_bad_addr
         $error("reset_hub: register addresses must differ");
      end
   endgenerate

   logic     mon_en;
   logic     mon_sel;
   logic     mcd_en;
   logic     pin_s;
   logic     sup_stat;
   logic     sup_ready;
   logic     sup_cause;
   logic     clk_missing;
   src_vec_t cause;
   src_vec_t winner;
   src_vec_t flags;
   logic     any;
   logic     any_d;
   logic     new_event;
   logic     skip;

   // register writes
   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n) begin
         mon_en  <= 1'b0;
         mon_sel <= 1'b0;
         mcd_en  <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == CTRL_ADDR) begin
            mon_en <= reg_wdata[CTRL_EN_BIT];
         end else if (reg_addr == SRC_ADDR) begin
            mon_sel <= reg_wdata[SRC_SEL_BIT];
            mcd_en  <= reg_wdata[SRC_MCD_BIT];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CTRL_ADDR) begin
         reg_rdata[CTRL_EN_BIT]   = mon_en;
         reg_rdata[CTRL_STAT_BIT] = sup_stat;
      end else if (reg_addr == SRC_ADDR) begin
         reg_rdata[NUM_SRC-1:0] = flags;
      end
   end

   rh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk   (ref_clk),
      .rst_n (por_n),
      .d     (ext_rst_n),
      .q     (pin_s)
   );

   rh_supmon #(.STAB(STAB_CYCLES), .SYNC(SYNC_STAGES)) u_supmon (
      .clk       (ref_clk),
      .rst_n     (por_n),
      .sup_above (sup_above),
      .en        (mon_en),
      .sel       (mon_sel),
      .status    (sup_stat),
      .ready     (sup_ready),
      .cause     (sup_cause)
   );

   rh_mcd #(.TIMEOUT(MCD_TIMEOUT), .SYNC(SYNC_STAGES)) u_mcd (
      .clk     (ref_clk),
      .rst_n   (por_n),
      .mon_clk (sys_clk),
      .enable  (mcd_en),
      .missing (clk_missing)
   );

   assign cause.pin = ~pin_s;
   assign cause.sup = sup_cause;
   assign cause.mcd = mcd_en & clk_missing;
   assign any       = |cause;
   assign winner    = pick_winner(cause);

   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n) any_d <= 1'b0;
      else        any_d <= any;
   end

   assign new_event = any & ~any_d;

   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n)         flags <= '0;
      else if (new_event) flags <= winner;
   end

   assign skip = new_event ? winner.sup : flags.sup;

   rh_stretch #(.HOLD(STRETCH_CYCLES)) u_stretch (
      .clk     (ref_clk),
      .rst_n   (por_n),
      .any     (any),
      .skip    (skip),
      .rst_out (sys_rst)
   );

   AST_PIN_FORCES_RST: assert property (@(posedge ref_clk) disable iff (!por_n)
      cause.pin |=> sys_rst); // R4
   AST_FLAGS_ONEHOT: assert property (@(posedge ref_clk) disable iff (!por_n)
      $onehot0(flags)); // R9
   AST_SUP_SKIPS_STRETCH: assert property (@(posedge ref_clk) disable iff (!por_n)
      (!any && any_d && flags.sup) |=> !sys_rst); // R10

   generate
      if (STRETCH_CYCLES > 0) begin : g_hold_chk
         AST_STRETCH_HOLDS: assert property (@(posedge ref_clk) disable iff (!por_n)
            (!any && any_d && !flags.sup) |=> sys_rst); // R10
      end
   endgenerate

endmodule

// File: tb/test_reset_hub.sv
`timescale 1ns/1ps
module test_reset_hub;

   localparam int TO   = 20;
   localparam int STAB = 16;
   localparam int STR  = 5;
   localparam logic [7:0] CA = 8'hFF;
   localparam logic [7:0] SA = 8'hFE;

   logic       ref_clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_clk = 1'b0;
   logic       ext_rst_n = 1'b1;
   logic       sup_above = 1'b1;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sys_rst;

   int    checks = 0;
   int    fails = 0;
   int    hi_cnt = 0;
   bit    clk_run = 1'b1;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 ref_clk = ~ref_clk;

   reset_hub #(
      .MCD_TIMEOUT(TO), .STAB_CYCLES(STAB), .STRETCH_CYCLES(STR), .SYNC_STAGES(2),
      .CTRL_ADDR(CA), .SRC_ADDR(SA)
   ) i_reset_hub (
      .ref_clk(ref_clk), .por_n(por_n), .sys_clk(sys_clk), .ext_rst_n(ext_rst_n),
      .sup_above(sup_above), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst)
   );

   // ---------------- behavioural reference model ----------------
   bit m_pq[$], m_sq[$], m_cq[$];
   bit m_cd, m_miss, m_en, m_sel, m_mcden, m_rdy, m_armd, m_anyd, m_rst;
   int m_mcnt, m_scnt, m_hold;
   bit [2:0] m_flags;

   task automatic model_reset();
      m_pq = '{1'b1, 1'b1}; m_sq = '{1'b1, 1'b1}; m_cq = '{1'b0, 1'b0};
      m_cd = 0; m_miss = 0; m_en = 0; m_sel = 0; m_mcden = 0; m_rdy = 0;
      m_armd = 0; m_anyd = 0; m_rst = 1; m_mcnt = 0; m_scnt = 0;
      m_hold = STR; m_flags = 3'b000;
   endtask

   always @(posedge ref_clk) begin
      if (!por_n) begin
         model_reset();
      end else begin
         bit pin_c, sup_s, edg, armed, haz, sup_c, mcd_c, any_c, ev, skip;
         bit [2:0] win;
         pin_c = !m_pq[1];
         sup_s = m_sq[1];
         edg   = m_cq[1] ^ m_cd;
         armed = m_en && m_sel;
         haz   = armed && !m_armd && !m_rdy;
         sup_c = haz || (armed && m_rdy && !sup_s);
         mcd_c = m_mcden && m_miss;
         any_c = pin_c || sup_c || mcd_c;
         ev    = any_c && !m_anyd;
         win   = pin_c ? 3'b001 : sup_c ? 3'b010 : mcd_c ? 3'b100 : 3'b000;
         skip  = ev ? (win == 3'b010) : (m_flags == 3'b010);
         if (any_c) begin m_rst = 1; m_hold = skip ? 0 : STR; end
         else if (m_hold != 0) begin m_rst = 1; m_hold--; end
         else m_rst = 0;
         if (ev) m_flags = win;
         m_anyd = any_c;
         m_armd = armed;
         if (!m_en) begin m_scnt = 0; m_rdy = 0; end
         else if (m_scnt == STAB) m_rdy = 1;
         else m_scnt++;
         if (!m_mcden || edg) begin m_mcnt = 0; m_miss = 0; end
         else if (m_mcnt == TO) m_miss = 1;
         else m_mcnt++;
         m_cd = m_cq[1];
         m_cq.push_front(sys_clk); void'(m_cq.pop_back());
         m_pq.push_front(ext_rst_n); void'(m_pq.pop_back());
         m_sq.push_front(sup_above); void'(m_sq.pop_back());
         if (reg_we) begin
            if (reg_addr == CA) m_en = reg_wdata[7];
            else if (reg_addr == SA) begin m_sel = reg_wdata[1]; m_mcden = reg_wdata[2]; end
         end
      end
   end

   function automatic logic [7:0] model_rd(logic [7:0] a);
      if (a == CA) return {m_en, m_sq[1], 6'b0};
      if (a == SA) return {5'b0, m_flags};
      return 8'h00;
   endfunction

   // per-clock comparison, away from the edge
   initial begin
      forever begin
         @(posedge ref_clk);
         #1;
         if (por_n && !done) begin
            checks += 2;
            if (sys_rst !== m_rst) begin
               fails++;
               $display("FAIL %s sys_rst actual=%0b expected=%0b at %0t", cur_req, sys_rst, m_rst, $time);
            end
            if (reg_rdata !== model_rd(reg_addr)) begin
               fails++;
               $display("FAIL %s reg_rdata actual=%02h expected=%02h at %0t", cur_req, reg_rdata, model_rd(reg_addr), $time);
            end
            if (sys_rst) hi_cnt++;
         end
      end
   end

   // monitored clock: toggles every 3 reference cycles while running
   initial begin
      forever begin
         repeat (3) @(negedge ref_clk);
         if (clk_run) sys_clk = ~sys_clk;
      end
   end

   task automatic summary();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge ref_clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge ref_clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge ref_clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
      @(negedge ref_clk);
      reg_addr = a;
      @(posedge ref_clk);
      #1;
      chk(req, int'(reg_rdata), int'(exp));
   endtask

   task automatic clr();
      @(negedge ref_clk);
      hi_cnt = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge ref_clk);
   endtask

   initial begin
      model_reset();
      idle(4);
      // R1: reset state and power-on stretch
      cur_req = "R1";
      hi_cnt = 0;
      por_n = 1'b1;
      idle(12);
      chk("R1 por stretch", hi_cnt, STR);
      rd_chk("R1 ctrl", CA, 8'h40);
      rd_chk("R1 src", SA, 8'h00);

      // R2: control register fields
      cur_req = "R2";
      wr(CA, 8'hBF);
      rd_chk("R2 enable set, reserved ignored", CA, 8'hC0);
      wr(CA, 8'h00);
      @(negedge ref_clk); sup_above = 1'b0;
      idle(3);
      rd_chk("R2 live status low", CA, 8'h00);
      @(negedge ref_clk); sup_above = 1'b1;
      idle(3);
      rd_chk("R2 live status high", CA, 8'h40);

      // R3: decode and flag write immunity
      cur_req = "R3";
      rd_chk("R3 unmapped", 8'h10, 8'h00);
      wr(SA, 8'hF9);
      rd_chk("R3 flags unaffected by write", SA, 8'h00);
      wr(SA, 8'h00);

      // R4: pin reset with stretch
      cur_req = "R4";
      clr();
      ext_rst_n = 1'b0;
      idle(4);
      ext_rst_n = 1'b1;
      idle(14);
      chk("R4 pin low 4 + stretch (R10)", hi_cnt, 4 + STR);
      rd_chk("R4 pin flag (R9)", SA, 8'h01);

      // R7/R6: unready select glitch, then low comparator before ready
      cur_req = "R7";
      clr();
      wr(CA, 8'h80);
      wr(SA, 8'h02);
      cur_req = "R6";
      sup_above = 1'b0;
      idle(3);
      sup_above = 1'b1;
      idle(6);
      chk("R7 one-cycle glitch, R6 no level reset before ready", hi_cnt, 1);
      rd_chk("R7 supply flag", SA, 8'h02);

      // R5/R10: level reset after ready, no stretch
      cur_req = "R5";
      idle(25);
      clr();
      sup_above = 1'b0;
      idle(6);
      sup_above = 1'b1;
      idle(10);
      chk("R5 level reset, R10 no stretch after supply", hi_cnt, 6);
      wr(CA, 8'h00);
      clr();
      sup_above = 1'b0;
      idle(4);
      sup_above = 1'b1;
      idle(6);
      chk("R5 disabled monitor ignored", hi_cnt, 0);
      wr(SA, 8'h00);

      // R8: missing clock detector
      cur_req = "R8";
      wr(SA, 8'h04);
      clr();
      idle(40);
      chk("R8 running clock no reset", hi_cnt, 0);
      clk_run = 1'b0;
      idle(40);
      chk("R8 stalled clock holds reset", int'(sys_rst), 1);
      clk_run = 1'b1;
      idle(20);
      chk("R8 released after edges return", int'(sys_rst), 0);
      rd_chk("R8 clock-loss flag", SA, 8'h04);
      wr(SA, 8'h00);
      clr();
      clk_run = 1'b0;
      idle(40);
      clk_run = 1'b1;
      chk("R8 disabled detector ignored", hi_cnt, 0);

      // R9: priority pin over supply, then supply alone
      cur_req = "R9";
      wr(CA, 8'h80);
      idle(STAB + 6);
      wr(SA, 8'h02);
      idle(3);
      clr();
      ext_rst_n = 1'b0; sup_above = 1'b0;
      idle(4);
      ext_rst_n = 1'b1; sup_above = 1'b1;
      idle(14);
      chk("R9 both causes, pin wins, R10 stretched", hi_cnt, 4 + STR);
      rd_chk("R9 pin flag wins", SA, 8'h01);
      clr();
      sup_above = 1'b0;
      idle(3);
      sup_above = 1'b1;
      idle(8);
      chk("R9 supply alone", hi_cnt, 3);
      rd_chk("R9 flags replaced", SA, 8'h02);

      idle(5);
      summary();
   end

endmodule